// File: doc/BRIEF.md
# Dual-Channel Conversion Result Registers

This block keeps the latest conversion result of two measurement channels, a capacitive channel and a voltage/temperature channel. It also derives the ready indications that tell a host when fresh data are waiting. A converter pulses a valid strobe with a result word for either channel. The bus front end reports each register byte it reads by address, and it marks the end of every read transaction with a STOP indication. The block keeps per-channel "unread" flags. It merges them into one active-low ready level according to which channels are enabled. It assembles a status byte that also carries an excitation-fault bit.

A channel's data are protected while the host is reading them. From the cycle in which any byte of that channel is read until the STOP that ends the transaction, a result arriving for that channel is thrown away. It is not queued. Reading the channel's last (lowest) byte and then ending the transaction marks the data as consumed. Results are stored exactly as delivered: the capacitive code is offset binary, with all-zeros meaning negative full scale, 0x800000 meaning zero and all-ones meaning positive full scale.

Top module: `conv_result_regs`

## Requirements
- R1: After reset the status byte reads 0x07, both result words read zero and `rdy_n` is high.
- R2: A valid result on a channel that is not blocked appears unchanged on that channel's data output in the following cycle, and that channel's flag goes low in the same cycle.
- R3: Status byte layout: bit 0 is the capacitive flag and bit 1 the voltage/temperature flag, both low for unread data. Bit 2 is the merged ready level, which is active low. Bit 3 is the excitation fault, which is active high. Bits 7 to 4 read zero.
- R4: The capacitive result occupies byte addresses 0x01..0x03 and the voltage/temperature result 0x04..0x06, with the high byte at the lowest address. A channel is blocked from the cycle one of its bytes is read through the cycle of the next STOP. A result arriving while its channel is blocked is discarded, and both data and flag stay unchanged.
- R5: A STOP ends the read. If the channel's last byte (0x03 or 0x06) was read in that transaction, the channel's flag returns high in the next cycle. A STOP without a last-byte read leaves the flag as it was.
- R6: With exactly one channel enabled, the merged ready level equals that channel's flag.
- R7: With both channels enabled, the merged ready level falls only once each channel has stored a result since the previous fall. It returns high when either flag is cleared by a read, or when a store opens the next round.
- R8: With no channel enabled, the merged ready level is high.
- R9: The excitation-fault bit is the fault input registered once per cycle.
- R10: The `rdy_n` output always equals status bit 2.
- R11: Reads at addresses outside 0x01..0x06 neither block a channel nor clear any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_en | input | 1 | Capacitive channel enabled |
| vt_en | input | 1 | Voltage/temperature channel enabled |
| cap_valid | input | 1 | Capacitive result strobe |
| cap_value | input | DATA_W | Capacitive result word |
| vt_valid | input | 1 | Voltage/temperature result strobe |
| vt_value | input | DATA_W | Voltage/temperature result word |
| rd_strobe | input | 1 | Bus front end reads one register byte this cycle |
| rd_addr | input | ADDR_W | Byte address of that read |
| bus_stop | input | 1 | Current read transaction ended with STOP |
| exc_fault | input | 1 | Excitation fault indication |
| cap_data | output | DATA_W | Stored capacitive result |
| vt_data | output | DATA_W | Stored voltage/temperature result |
| status_byte | output | 8 | Status register contents |
| rdy_n | output | 1 | Merged ready level, active low |

## Verification
The bench builds the block with its default DATA_W of 24 and ADDR_W of 8. With these values each channel spans three byte addresses, so the capacitive last byte (0x03) sits right next to the first voltage/temperature byte (0x04). The boundary between the two windows and the lone-last-byte clear are therefore both reachable. The offset-binary extremes 0x000000, 0x800000 and 0xFFFFFF pass through unchanged. Enable combinations are switched between one, two and no channels, so that every merge path of the ready level is visited.

// File: rtl/conv_result_pkg.sv
package conv_result_pkg;

  typedef struct packed {
    logic [3:0] zero;
    logic       exc_fault;
    logic       rdy_all_n;
    logic       rdy_vt_n;
    logic       rdy_cap_n;
  } status_t;

  // First byte address of channel ch (0 = capacitive, 1 = voltage/temperature)
  function automatic int chan_base(int ch, int nbytes);
    return 1 + ch * nbytes;
  endfunction

  function automatic logic in_window(int addr, int base, int count);
    return (addr >= base) && (addr < base + count);
  endfunction

  // Merged active-low ready level
  function automatic logic merge_ready(logic cap_en, logic vt_en, logic cap_n,
                                       logic vt_n, logic both_n);
    logic r;
    case ({cap_en, vt_en})
      2'b11:   r = both_n;
      2'b10:   r = cap_n;
      2'b01:   r = vt_n;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/conv_result_chan.sv
module conv_result_chan
  import conv_result_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 8,
  parameter int BASE   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_value,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              bus_stop,
  output logic [DATA_W-1:0] data_q,
  output logic              flag_n,
  output logic              stored,
  output logic              cleared,
  output logic              busy
);
  localparam int NBYTES = DATA_W / 8;
  localparam int LAST   = BASE + NBYTES - 1;

  logic busy_q, last_q, hit, last_hit;

  assign hit      = rd_strobe && in_window(int'(rd_addr), BASE, NBYTES);
  assign last_hit = rd_strobe && (int'(rd_addr) == LAST);
  assign stored   = res_valid && !(busy_q || hit);
  assign cleared  = bus_stop && (last_q || last_hit);
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else if (bus_stop) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (hit)      busy_q <= 1'b1;
      if (last_hit) last_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_n <= 1'b1;
    end else if (stored) begin
      data_q <= res_value;
      flag_n <= 1'b0;
    end else if (cleared) begin
      flag_n <= 1'b1;
    end
  end

endmodule

// File: rtl/conv_ready_merge.sv
module conv_ready_merge
  import conv_result_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic vt_en,
  input  logic cap_store,
  input  logic vt_store,
  input  logic cap_clear,
  input  logic vt_clear,
  input  logic cap_flag_n,
  input  logic vt_flag_n,
  output logic rdy_n
);
  logic both, complete, got_cap, got_vt, both_n;

  assign both     = cap_en && vt_en;
  assign complete = both && (got_cap || cap_store) && (got_vt || vt_store);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_cap <= 1'b0;
      got_vt  <= 1'b0;
      both_n  <= 1'b1;
    end else if (!both) begin
      got_cap <= 1'b0;
      got_vt  <= 1'b0;
      both_n  <= 1'b1;
    end else if (complete) begin
      got_cap <= 1'b0;
      got_vt  <= 1'b0;
      both_n  <= 1'b0;
    end else begin
      if (cap_store) got_cap <= 1'b1;
      if (vt_store)  got_vt  <= 1'b1;
      if (cap_store || vt_store || cap_clear || vt_clear) both_n <= 1'b1;
    end
  end

  assign rdy_n = merge_ready(cap_en, vt_en, cap_flag_n, vt_flag_n, both_n);

endmodule

// File: rtl/conv_result_regs.sv
module conv_result_regs
  import conv_result_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              vt_en,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_value,
  input  logic              vt_valid,
  input  logic [DATA_W-1:0] vt_value,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              bus_stop,
  input  logic              exc_fault,
  output logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] vt_data,
  output logic [7:0]        status_byte,
  output logic              rdy_n
);
  localparam int NCH    = 2;
  localparam int NBYTES = DATA_W / 8;

  logic [NCH-1:0]             valid_v, flag_v, stored_v, cleared_v, busy_v;
  logic [NCH-1:0][DATA_W-1:0] value_v, data_v;

  assign valid_v = {vt_valid, cap_valid};
  assign value_v = {vt_value, cap_value};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    conv_result_chan #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W),
      .BASE  (chan_base(ch, NBYTES))
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .res_valid(valid_v[ch]),
      .res_value(value_v[ch]),
      .rd_strobe(rd_strobe),
      .rd_addr  (rd_addr),
      .bus_stop (bus_stop),
      .data_q   (data_v[ch]),
      .flag_n   (flag_v[ch]),
      .stored   (stored_v[ch]),
      .cleared  (cleared_v[ch]),
      .busy     (busy_v[ch])
    );
  end

  // Named events for the checker
  logic cap_stored, vt_stored, cap_cleared, vt_cleared, cap_busy, vt_busy;
  logic cap_flag_n, vt_flag_n, exc_q;
  assign cap_stored  = stored_v[0];
  assign vt_stored   = stored_v[1];
  assign cap_cleared = cleared_v[0];
  assign vt_cleared  = cleared_v[1];
  assign cap_busy    = busy_v[0];
  assign vt_busy     = busy_v[1];
  assign cap_flag_n  = flag_v[0];
  assign vt_flag_n   = flag_v[1];

  conv_ready_merge u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .vt_en     (vt_en),
    .cap_store (cap_stored),
    .vt_store  (vt_stored),
    .cap_clear (cap_cleared),
    .vt_clear  (vt_cleared),
    .cap_flag_n(cap_flag_n),
    .vt_flag_n (vt_flag_n),
    .rdy_n     (rdy_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc_q <= 1'b0;
    else        exc_q <= exc_fault;
  end

  status_t st;
  always_comb begin
    st.zero      = '0;
    st.exc_fault = exc_q;
    st.rdy_all_n = rdy_n;
    st.rdy_vt_n  = vt_flag_n;
    st.rdy_cap_n = cap_flag_n;
  end

  assign status_byte = st;
  assign cap_data    = data_v[0];
  assign vt_data     = data_v[1];

endmodule

// File: rtl/conv_result_regs_chk.sv
module conv_result_regs_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_en,
  input logic              vt_en,
  input logic [DATA_W-1:0] cap_value,
  input logic              exc_fault,
  input logic [DATA_W-1:0] cap_data,
  input logic [DATA_W-1:0] vt_data,
  input logic [7:0]        status_byte,
  input logic              rdy_n,
  input logic              cap_stored,
  input logic              vt_cleared,
  input logic              cap_busy,
  input logic              vt_busy,
  input logic              cap_flag_n
);
  p_store_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stored |=> !status_byte[0]);

  p_store_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stored |=> cap_data == $past(cap_value));

  p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_busy |=> $stable(cap_data));

  p_vt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vt_busy |=> $stable(vt_data));

  p_clear_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vt_cleared |=> status_byte[1]);

  p_single_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !vt_en) |-> (rdy_n == cap_flag_n));

  p_none_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !vt_en) |-> rdy_n);

  p_fault_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status_byte[3] == $past(exc_fault));

endmodule

bind conv_result_regs conv_result_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cap_en     (cap_en),
  .vt_en      (vt_en),
  .cap_value  (cap_value),
  .exc_fault  (exc_fault),
  .cap_data   (cap_data),
  .vt_data    (vt_data),
  .status_byte(status_byte),
  .rdy_n      (rdy_n),
  .cap_stored (cap_stored),
  .vt_cleared (vt_cleared),
  .cap_busy   (cap_busy),
  .vt_busy    (vt_busy),
  .cap_flag_n (cap_flag_n)
);

// File: tb/test_conv_result_regs.sv
module test_conv_result_regs;
  localparam int DATA_W = 24;
  localparam int ADDR_W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_en = 1'b1, vt_en = 1'b1;
  logic cap_valid = 1'b0, vt_valid = 1'b0;
  logic [DATA_W-1:0] cap_value = '0, vt_value = '0;
  logic rd_strobe = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic bus_stop = 1'b0, exc_fault = 1'b0;
  logic [DATA_W-1:0] cap_data, vt_data;
  logic [7:0] status_byte;
  logic rdy_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_result_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_conv_result_regs (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .vt_en(vt_en),
    .cap_valid(cap_valid), .cap_value(cap_value),
    .vt_valid(vt_valid), .vt_value(vt_value),
    .rd_strobe(rd_strobe), .rd_addr(rd_addr), .bus_stop(bus_stop),
    .exc_fault(exc_fault), .cap_data(cap_data), .vt_data(vt_data),
    .status_byte(status_byte), .rdy_n(rdy_n)
  );

  // Scoreboard: sel 0 status, 1 cap_data, 2 vt_data, 3 rdy_n
  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic push(int sel, logic [31:0] exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // status check plus pin mirror (R10)
  task automatic want_status(logic [7:0] s, string req);
    push(0, {24'd0, s}, req);
    push(3, {31'd0, s[2]}, "R10");
  endtask

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0:       return {24'd0, status_byte};
      1:       return {8'd0, cap_data};
      2:       return {8'd0, vt_data};
      default: return {31'd0, rdy_n};
    endcase
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        got = observe(it.sel);
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cap_res(logic [DATA_W-1:0] v);
    cap_valid = 1'b1; cap_value = v; tick(); cap_valid = 1'b0;
  endtask

  task automatic vt_res(logic [DATA_W-1:0] v);
    vt_valid = 1'b1; vt_value = v; tick(); vt_valid = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a);
    rd_strobe = 1'b1; rd_addr = a; tick(); rd_strobe = 1'b0;
  endtask

  task automatic stop();
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
  endtask

  task automatic finish_run();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    want_status(8'h07, "R1");
    push(1, 32'h0, "R1");
    push(2, 32'h0, "R1");
    tick();

    // Capacitive only: R2, R6, R3 layout
    cap_en = 1'b1; vt_en = 1'b0;
    cap_res(24'h800000);
    push(1, 32'h800000, "R2");
    want_status(8'h02, "R6");

    // R11: foreign addresses neither block nor clear
    rd(8'h00); rd(8'h07); stop();
    want_status(8'h02, "R11");
    cap_res(24'hFFFFFF);
    push(1, 32'hFFFFFF, "R11");

    // R4: result during read is dropped; R5: clear after last byte + STOP
    rd(8'h01);
    cap_res(24'h000000);
    push(1, 32'hFFFFFF, "R4");
    want_status(8'h02, "R4");
    rd(8'h02); rd(8'h03); stop();
    want_status(8'h07, "R5");

    // R5: STOP without last byte keeps the flag
    cap_res(24'h000000);
    push(1, 32'h000000, "R2");
    rd(8'h01); rd(8'h02); stop();
    want_status(8'h02, "R5");
    cap_res(24'h123456);
    push(1, 32'h123456, "R4");
    rd(8'h03); stop();
    want_status(8'h07, "R5");

    // Both enabled: R7
    vt_en = 1'b1;
    cap_res(24'hAAAAAA);
    want_status(8'h06, "R7");
    vt_res(24'h555555);
    push(2, 32'h555555, "R2");
    want_status(8'h00, "R7");
    cap_res(24'h0F0F0F);
    want_status(8'h04, "R7");
    rd(8'h04);
    vt_res(24'hDEADBE);
    push(2, 32'h555555, "R4");
    rd(8'h05); rd(8'h06); stop();
    want_status(8'h06, "R5");
    vt_res(24'h010203);
    want_status(8'h00, "R7");
    rd(8'h01); rd(8'h02); rd(8'h03); stop();
    push(1, 32'h0F0F0F, "R3");
    want_status(8'h05, "R7");

    // R8: nothing enabled
    cap_en = 1'b0; vt_en = 1'b0;
    #1;
    want_status(8'h05, "R8");
    tick();

    // R6: voltage/temperature only
    vt_en = 1'b1;
    #1;
    want_status(8'h01, "R6");
    tick();

    // R9: fault bit registered
    exc_fault = 1'b1; tick();
    want_status(8'h09, "R9");
    exc_fault = 1'b0; tick();
    want_status(8'h01, "R9");

    done = 1'b1;
    finish_run();
  end

endmodule